// File: doc/BRIEF.md
# Privileged Return and System-Instruction Permission Unit

This block owns the hart's current privilege mode together with the per-level interrupt-enable bits and the saved "previous" fields that a trap would have left behind. It is presented, one at a time, with four privileged system operations: return from a machine-level trap, return from a supervisor-level trap, wait-for-interrupt, and the address-translation fence. For each one it decides whether the operation is permitted in the current mode under three trap-control inputs. A forbidden operation produces a one-cycle illegal pulse. A permitted return restores the mode and interrupt enable from the saved fields and emits the matching saved exception PC as the next fetch address.

A permitted wait or fence is only a permission decision here. The waiting itself and the translation flush belong to other blocks. The trap-control inputs and both saved exception PCs come from neighbouring control registers. A load port lets the trap-entry logic or a control-register write place a whole new status image into the unit.

Top module: `privret_unit`

## Requirements
- R1: After synchronous reset the mode is machine (encoding 3), all four enable bits (current and previous, both levels) are 0, both previous-mode fields are user (0), and the illegal and redirect outputs are 0.
- R2: A machine-level return (op code 0) is illegal unless the current mode is machine (3).
- R3: A supervisor-level return (op code 1) is illegal in user mode (0), and in supervisor mode (1) when `trap_sret_i` is 1.
- R4: Wait-for-interrupt (op code 2) is illegal in user mode, and in supervisor mode when `trap_wfi_i` is 1. When permitted it changes no state and gives no redirect.
- R5: The translation fence (op code 3) is illegal in user mode, and in supervisor mode when `trap_fence_i` is 1. When permitted it changes no state and gives no redirect.
- R6: A permitted machine-level return sets the mode to the machine previous-mode field and copies the machine previous enable into the machine enable. It then sets the machine previous enable to 1 and the machine previous-mode field to user. One cycle after the operation it pulses `redirect_o` with `next_pc_o` equal to `mepc_i`.
- R7: A permitted supervisor-level return sets the mode to the supervisor previous-mode bit (0 gives user, 1 gives supervisor) and copies the supervisor previous enable into the supervisor enable. It then sets the supervisor previous enable to 1 and the supervisor previous-mode bit to 0. One cycle after the operation it pulses `redirect_o` with `next_pc_o` equal to `sepc_i`.
- R8: An illegal operation raises `illegal_o` for exactly one cycle, one cycle after the operation. It changes no state and never coincides with a redirect.
- R9: A load (`ld_en_i` = 1 with no operation presented) writes every status field. A reserved mode value of 2 in either the mode or the machine previous-mode field is stored as user (0), so the mode never reads 2.
- R10: When an operation and a load arrive in the same cycle, the operation is judged on the status held before that edge and the load is discarded.
- R11: In machine mode all four operations are permitted whatever the three trap-control inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid_i | input | 1 | An operation is presented this cycle |
| op_code_i | input | 2 | 0 machine return, 1 supervisor return, 2 wait, 3 translation fence |
| trap_sret_i | input | 1 | Forbid supervisor return in supervisor mode |
| trap_wfi_i | input | 1 | Forbid wait-for-interrupt in supervisor mode |
| trap_fence_i | input | 1 | Forbid translation fence in supervisor mode |
| mepc_i | input | PC_W | Saved machine exception PC |
| sepc_i | input | PC_W | Saved supervisor exception PC |
| ld_en_i | input | 1 | Load a new status image |
| ld_mode_i | input | 2 | Mode to load |
| ld_m_pmode_i | input | 2 | Machine previous-mode field to load |
| ld_m_pie_i | input | 1 | Machine previous enable to load |
| ld_m_ie_i | input | 1 | Machine enable to load |
| ld_s_pmode_i | input | 1 | Supervisor previous-mode bit to load |
| ld_s_pie_i | input | 1 | Supervisor previous enable to load |
| ld_s_ie_i | input | 1 | Supervisor enable to load |
| mode_o | output | 2 | Current privilege mode |
| m_ie_o | output | 1 | Machine interrupt enable |
| s_ie_o | output | 1 | Supervisor interrupt enable |
| m_pie_o | output | 1 | Machine previous enable |
| s_pie_o | output | 1 | Supervisor previous enable |
| m_pmode_o | output | 2 | Machine previous-mode field |
| s_pmode_o | output | 1 | Supervisor previous-mode bit |
| illegal_o | output | 1 | One-cycle illegal-operation pulse |
| redirect_o | output | 1 | One-cycle pulse: take next_pc_o |
| next_pc_o | output | PC_W | Return target PC |

## Verification
A status load and a privileged operation can land on the same clock edge, and the unit must then judge and execute the operation on the pre-edge status. The bench provokes this by raising the load strobe and the operation strobe together, once with a permitted machine return and once with a machine return from user mode that must be refused. In both cases the loaded image differs from the held one in mode and previous-mode fields. The result is judged by whether the mode after the edge comes from the old previous-mode field and by whether the illegal pulse fires, which a design that let the load win would get wrong.

// File: rtl/privret_pkg.sv
package privret_pkg;
  localparam logic [1:0] MODE_USER = 2'd0;
  localparam logic [1:0] MODE_SUPV = 2'd1;
  localparam logic [1:0] MODE_MACH = 2'd3;

  typedef enum logic [1:0] {
    OP_MRET   = 2'd0,
    OP_SRET   = 2'd1,
    OP_WFI    = 2'd2,
    OP_FENCE  = 2'd3
  } sysop_e;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] m_pmode;
    logic       m_pie;
    logic       m_ie;
    logic       s_pmode;
    logic       s_pie;
    logic       s_ie;
  } privstate_t;

  localparam privstate_t STATE_RESET = '{
    mode: MODE_MACH, m_pmode: MODE_USER, m_pie: 1'b0, m_ie: 1'b0,
    s_pmode: 1'b0, s_pie: 1'b0, s_ie: 1'b0};

  function automatic logic [1:0] clean_mode(input logic [1:0] m);
    return (m == 2'b10) ? MODE_USER : m;
  endfunction
endpackage

// File: rtl/privret_legal.sv
module privret_legal
  import privret_pkg::*;
(
  input  logic [1:0] mode,
  input  sysop_e     op,
  input  logic       trap_sret,
  input  logic       trap_wfi,
  input  logic       trap_fence,
  output logic       illegal
);
  logic in_user, in_supv;
  assign in_user = (mode == MODE_USER);
  assign in_supv = (mode == MODE_SUPV);

  always_comb begin
    case (op)
      OP_MRET:  illegal = (mode != MODE_MACH);
      OP_SRET:  illegal = in_user || (in_supv && trap_sret);
      OP_WFI:   illegal = in_user || (in_supv && trap_wfi);
      default:  illegal = in_user || (in_supv && trap_fence);
    endcase
  end
endmodule

// File: rtl/privret_next.sv
module privret_next
  import privret_pkg::*;
(
  input  privstate_t cur,
  input  logic       valid,
  input  sysop_e     op,
  input  logic       illegal,
  input  logic       load,
  input  privstate_t load_img,
  output privstate_t nxt,
  output logic       redirect,
  output logic       use_sepc
);
  always_comb begin
    nxt      = cur;
    redirect = 1'b0;
    use_sepc = 1'b0;
    if (valid) begin
      if (!illegal) begin
        case (op)
          OP_MRET: begin
            nxt.mode    = cur.m_pmode;
            nxt.m_ie    = cur.m_pie;
            nxt.m_pie   = 1'b1;
            nxt.m_pmode = MODE_USER;
            redirect    = 1'b1;
          end
          OP_SRET: begin
            nxt.mode    = {1'b0, cur.s_pmode};
            nxt.s_ie    = cur.s_pie;
            nxt.s_pie   = 1'b1;
            nxt.s_pmode = 1'b0;
            redirect    = 1'b1;
            use_sepc    = 1'b1;
          end
          default: ;
        endcase
      end
    end else if (load) begin
      nxt         = load_img;
      nxt.mode    = clean_mode(load_img.mode);
      nxt.m_pmode = clean_mode(load_img.m_pmode);
    end
  end
endmodule

// File: rtl/privret_unit.sv
module privret_unit
  import privret_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid_i,
  input  logic [1:0]      op_code_i,
  input  logic            trap_sret_i,
  input  logic            trap_wfi_i,
  input  logic            trap_fence_i,
  input  logic [PC_W-1:0] mepc_i,
  input  logic [PC_W-1:0] sepc_i,
  input  logic            ld_en_i,
  input  logic [1:0]      ld_mode_i,
  input  logic [1:0]      ld_m_pmode_i,
  input  logic            ld_m_pie_i,
  input  logic            ld_m_ie_i,
  input  logic            ld_s_pmode_i,
  input  logic            ld_s_pie_i,
  input  logic            ld_s_ie_i,
  output logic [1:0]      mode_o,
  output logic            m_ie_o,
  output logic            s_ie_o,
  output logic            m_pie_o,
  output logic            s_pie_o,
  output logic [1:0]      m_pmode_o,
  output logic            s_pmode_o,
  output logic            illegal_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] next_pc_o
);
  sysop_e     op;
  privstate_t state_q, state_d, load_img;
  logic       illegal_c, redirect_c, use_sepc_c;
  logic       illegal_q, redirect_q;
  logic [PC_W-1:0] npc_q;

  assign op       = sysop_e'(op_code_i);
  assign load_img = '{mode: ld_mode_i, m_pmode: ld_m_pmode_i, m_pie: ld_m_pie_i,
                      m_ie: ld_m_ie_i, s_pmode: ld_s_pmode_i, s_pie: ld_s_pie_i,
                      s_ie: ld_s_ie_i};

  privret_legal u_legal (
    .mode       (state_q.mode),
    .op         (op),
    .trap_sret  (trap_sret_i),
    .trap_wfi   (trap_wfi_i),
    .trap_fence (trap_fence_i),
    .illegal    (illegal_c)
  );

  privret_next u_next (
    .cur      (state_q),
    .valid    (op_valid_i),
    .op       (op),
    .illegal  (illegal_c),
    .load     (ld_en_i),
    .load_img (load_img),
    .nxt      (state_d),
    .redirect (redirect_c),
    .use_sepc (use_sepc_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= STATE_RESET;
      illegal_q  <= 1'b0;
      redirect_q <= 1'b0;
      npc_q      <= '0;
    end else begin
      state_q    <= state_d;
      illegal_q  <= op_valid_i && illegal_c;
      redirect_q <= redirect_c;
      if (redirect_c) npc_q <= use_sepc_c ? sepc_i : mepc_i;
    end
  end

  assign mode_o     = state_q.mode;
  assign m_ie_o     = state_q.m_ie;
  assign s_ie_o     = state_q.s_ie;
  assign m_pie_o    = state_q.m_pie;
  assign s_pie_o    = state_q.s_pie;
  assign m_pmode_o  = state_q.m_pmode;
  assign s_pmode_o  = state_q.s_pmode;
  assign illegal_o  = illegal_q;
  assign redirect_o = redirect_q;
  assign next_pc_o  = npc_q;

  a_r2_mret_needs_machine: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_code_i == 2'd0 && mode_o != MODE_MACH) |=> illegal_o);

  a_r3_sret_refused_in_user: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_code_i == 2'd1 && mode_o == MODE_USER) |=> (illegal_o && !redirect_o));

  a_r6_mret_resets_prev: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_code_i == 2'd0 && mode_o == MODE_MACH)
      |=> (redirect_o && m_pie_o && m_pmode_o == MODE_USER));

  a_r8_illegal_freezes_state: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> (mode_o == $past(mode_o) && m_ie_o == $past(m_ie_o) &&
                   s_ie_o == $past(s_ie_o) && m_pie_o == $past(m_pie_o) &&
                   s_pie_o == $past(s_pie_o) && m_pmode_o == $past(m_pmode_o) &&
                   s_pmode_o == $past(s_pmode_o)));

  a_r8_no_illegal_redirect: assert property (@(posedge clk) disable iff (rst)
    !(illegal_o && redirect_o));

  a_r9_mode_never_reserved: assert property (@(posedge clk) disable iff (rst)
    mode_o != 2'b10);
endmodule

// File: tb/privret_unit_test.sv
module privret_unit_test;
  localparam int PC_W = 32;
  localparam logic [31:0] MEPC = 32'h0000_1000;
  localparam logic [31:0] SEPC = 32'h0000_2000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid_i = 1'b0;
  logic [1:0] op_code_i = 2'd0;
  logic trap_sret_i = 1'b0, trap_wfi_i = 1'b0, trap_fence_i = 1'b0;
  logic [PC_W-1:0] mepc_i = MEPC, sepc_i = SEPC;
  logic ld_en_i = 1'b0;
  logic [1:0] ld_mode_i = 2'd0, ld_m_pmode_i = 2'd0;
  logic ld_m_pie_i = 1'b0, ld_m_ie_i = 1'b0, ld_s_pmode_i = 1'b0;
  logic ld_s_pie_i = 1'b0, ld_s_ie_i = 1'b0;
  logic [1:0] mode_o, m_pmode_o;
  logic m_ie_o, s_ie_o, m_pie_o, s_pie_o, s_pmode_o, illegal_o, redirect_o;
  logic [PC_W-1:0] next_pc_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  privret_unit #(.PC_W(PC_W)) uut (
    .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
    .trap_sret_i(trap_sret_i), .trap_wfi_i(trap_wfi_i), .trap_fence_i(trap_fence_i),
    .mepc_i(mepc_i), .sepc_i(sepc_i), .ld_en_i(ld_en_i), .ld_mode_i(ld_mode_i),
    .ld_m_pmode_i(ld_m_pmode_i), .ld_m_pie_i(ld_m_pie_i), .ld_m_ie_i(ld_m_ie_i),
    .ld_s_pmode_i(ld_s_pmode_i), .ld_s_pie_i(ld_s_pie_i), .ld_s_ie_i(ld_s_ie_i),
    .mode_o(mode_o), .m_ie_o(m_ie_o), .s_ie_o(s_ie_o), .m_pie_o(m_pie_o),
    .s_pie_o(s_pie_o), .m_pmode_o(m_pmode_o), .s_pmode_o(s_pmode_o),
    .illegal_o(illegal_o), .redirect_o(redirect_o), .next_pc_o(next_pc_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [1:0] md, input logic mie,
                           input logic mpie, input logic [1:0] mpp, input logic sie,
                           input logic spie, input logic spp);
    chk(req, "mode", 32'(mode_o), 32'(md));
    chk(req, "m_ie", 32'(m_ie_o), 32'(mie));
    chk(req, "m_pie", 32'(m_pie_o), 32'(mpie));
    chk(req, "m_pmode", 32'(m_pmode_o), 32'(mpp));
    chk(req, "s_ie", 32'(s_ie_o), 32'(sie));
    chk(req, "s_pie", 32'(s_pie_o), 32'(spie));
    chk(req, "s_pmode", 32'(s_pmode_o), 32'(spp));
  endtask

  task automatic set_load(input logic [1:0] md, input logic [1:0] mpp, input logic mpie,
                          input logic mie, input logic spp, input logic spie, input logic sie);
    ld_en_i = 1'b1; ld_mode_i = md; ld_m_pmode_i = mpp; ld_m_pie_i = mpie;
    ld_m_ie_i = mie; ld_s_pmode_i = spp; ld_s_pie_i = spie; ld_s_ie_i = sie;
  endtask

  task automatic do_load(input logic [1:0] md, input logic [1:0] mpp, input logic mpie,
                         input logic mie, input logic spp, input logic spie, input logic sie);
    @(negedge clk);
    set_load(md, mpp, mpie, mie, spp, spie, sie);
    @(negedge clk);
    ld_en_i = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op);
    @(negedge clk);
    op_valid_i = 1'b1; op_code_i = op;
    @(negedge clk);
    op_valid_i = 1'b0;
  endtask

  task automatic expect_pulse(input string req, input logic ill, input logic redir);
    chk(req, "illegal", 32'(illegal_o), 32'(ill));
    chk(req, "redirect", 32'(redirect_o), 32'(redir));
  endtask

  task automatic t_reset;
    chk_state("R1", 2'd3, 0, 0, 2'd0, 0, 0, 0);
    expect_pulse("R1", 0, 0);
  endtask

  task automatic t_mret;
    do_load(2'd3, 2'd1, 1, 0, 0, 0, 0);
    issue(2'd0);
    expect_pulse("R6", 0, 1);
    chk("R6", "next_pc", next_pc_o, MEPC);
    chk_state("R6", 2'd1, 1, 1, 2'd0, 0, 0, 0);
    @(negedge clk);
    chk("R6", "redirect drops", 32'(redirect_o), 0);
    issue(2'd0);
    expect_pulse("R2", 1, 0);
    chk_state("R8", 2'd1, 1, 1, 2'd0, 0, 0, 0);
    @(negedge clk);
    chk("R8", "pulse one cycle", 32'(illegal_o), 0);
  endtask

  task automatic t_sret;
    do_load(2'd1, 2'd0, 0, 0, 0, 1, 0);
    issue(2'd1);
    expect_pulse("R7", 0, 1);
    chk("R7", "next_pc", next_pc_o, SEPC);
    chk_state("R7", 2'd0, 0, 0, 2'd0, 1, 1, 0);
    issue(2'd1);
    expect_pulse("R3", 1, 0);
    chk("R3", "mode user kept", 32'(mode_o), 0);
    do_load(2'd1, 2'd0, 0, 0, 1, 0, 1);
    trap_sret_i = 1'b1;
    issue(2'd1);
    expect_pulse("R3", 1, 0);
    chk_state("R3", 2'd1, 0, 0, 2'd0, 1, 0, 1);
    trap_sret_i = 1'b0;
  endtask

  task automatic t_wfi_fence;
    do_load(2'd1, 2'd0, 0, 1, 0, 0, 1);
    issue(2'd2);
    expect_pulse("R4", 0, 0);
    chk_state("R4", 2'd1, 1, 0, 2'd0, 1, 0, 0);
    trap_wfi_i = 1'b1;
    issue(2'd2);
    expect_pulse("R4", 1, 0);
    trap_wfi_i = 1'b0;
    issue(2'd3);
    expect_pulse("R5", 0, 0);
    chk("R5", "mode", 32'(mode_o), 1);
    trap_fence_i = 1'b1;
    issue(2'd3);
    expect_pulse("R5", 1, 0);
    trap_fence_i = 1'b0;
    do_load(2'd0, 2'd0, 0, 0, 0, 0, 0);
    issue(2'd2);
    expect_pulse("R4", 1, 0);
    issue(2'd3);
    expect_pulse("R5", 1, 0);
  endtask

  task automatic t_machine_free;
    do_load(2'd3, 2'd0, 0, 1, 1, 0, 0);
    trap_sret_i = 1'b1; trap_wfi_i = 1'b1; trap_fence_i = 1'b1;
    issue(2'd2);
    expect_pulse("R11", 0, 0);
    issue(2'd3);
    expect_pulse("R11", 0, 0);
    issue(2'd1);
    expect_pulse("R11", 0, 1);
    chk_state("R11", 2'd1, 1, 0, 2'd0, 0, 1, 0);
    trap_sret_i = 1'b0; trap_wfi_i = 1'b0; trap_fence_i = 1'b0;
  endtask

  task automatic t_load_reserved;
    do_load(2'd2, 2'd2, 1, 1, 1, 1, 1);
    chk_state("R9", 2'd0, 1, 1, 2'd0, 1, 1, 1);
    do_load(2'd3, 2'd3, 0, 1, 0, 1, 0);
    chk_state("R9", 2'd3, 1, 0, 2'd3, 0, 1, 0);
  endtask

  task automatic t_collide;
    do_load(2'd3, 2'd1, 1, 0, 0, 0, 0);
    @(negedge clk);
    set_load(2'd0, 2'd3, 0, 1, 1, 1, 1);
    op_valid_i = 1'b1; op_code_i = 2'd0;
    @(negedge clk);
    op_valid_i = 1'b0; ld_en_i = 1'b0;
    expect_pulse("R10", 0, 1);
    chk_state("R10", 2'd1, 1, 1, 2'd0, 0, 0, 0);
    do_load(2'd0, 2'd3, 0, 0, 0, 0, 0);
    @(negedge clk);
    set_load(2'd3, 2'd1, 1, 1, 1, 1, 1);
    op_valid_i = 1'b1; op_code_i = 2'd0;
    @(negedge clk);
    op_valid_i = 1'b0; ld_en_i = 1'b0;
    expect_pulse("R10", 1, 0);
    chk_state("R10", 2'd0, 0, 0, 2'd3, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_mret();
    t_sret();
    t_wfi_fence();
    t_machine_free();
    t_load_reserved();
    t_collide();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule